// File: doc/BRIEF.md
# Synchronous processor bus slave port

This block is the clocked slave port between an external microprocessor bus and the internal register and memory space of a switching device. The host drives a 15-bit address, an active-low address strobe, an active-low chip select and a read/write level. Write data arrives on an 8-bit input lane. Read data leaves on an 8-bit output lane with a drive enable, which the pad ring merges into one bidirectional bus. Each accepted access becomes a single request on an internal req/done handshake of variable length. The port ends every access with a transfer acknowledge that is low for one clock.

A one-bit control setting picks the clock in which chip select qualifies an access. The setting lives at a fixed local address inside the port and is bit 7 of the byte written there. With the bit at 0, chip select is sampled on the edge after the strobe edge. With the bit at 1, chip select is sampled on the strobe edge itself, which saves one clock on every access. An access that is not qualified is dropped without any request or acknowledge.

The controller has six states. IDLE waits for the strobe. QUAL is the extra chip-select sampling cycle of late mode. BUSY holds the internal request. LOCAL serves the control setting. ACK is the single acknowledge cycle. HOLD waits for the strobe to go high. The transitions are:
- IDLE→QUAL on a strobe in late mode.
- IDLE→BUSY or IDLE→LOCAL on a strobe with chip select in early mode.
- IDLE→HOLD on a strobe without chip select in early mode.
- QUAL→BUSY or QUAL→LOCAL with chip select.
- QUAL→HOLD without chip select.
- BUSY→ACK on done.
- LOCAL→ACK always.
- ACK→IDLE with the strobe high.
- ACK→HOLD with the strobe low.
- HOLD→IDLE once the strobe is high.

Top module: `sync_host_port`

## Requirements
- R1: An access starts only when `host_as_n` is sampled low on a rising clock edge while the port is idle.
- R2: With the control bit at 1, `host_cs_n` must be low on the strobe edge. Otherwise the access is dropped, with no `int_req` and no acknowledge. Chip select on the following edge has no effect.
- R3: With the control bit at 0, `host_cs_n` is sampled on the edge after the strobe edge, and its level on the strobe edge has no effect. If it is high on that later edge, the access is dropped, with no `int_req` and no acknowledge.
- R4: Let L be the number of edges from the first edge of `int_req` up to and including the edge where `int_done` is sampled. The acknowledge is then visible after edge L (control bit 1) or edge L+1 (control bit 0), counting the strobe edge as edge 0.
- R5: Address, read/write and write data are latched on the qualifying edge. `int_req` rises after that edge and stays high, with `int_addr`, `int_rnw` and `int_wdata` unchanged, until `int_done` is sampled high.
- R6: `host_ack_n` is low for exactly one clock. That clock directly follows the edge where `int_done` was sampled high (or the local cycle, for the control setting).
- R7: `host_doe` is 1 only in the acknowledge clock of a read, with `host_dout` carrying the returned data. It is 0 on the next clock and in every cycle of a write.
- R8: A strobe during an access in progress, or one still held after its acknowledge, starts nothing. The port returns to idle only on an edge after the acknowledge where `host_as_n` is high.
- R9: Address `CTRL_ADDR` (default 15'h7F00) is served locally, with no `int_req`. A write there stores data bit 7 as the control bit. A read there returns the control bit in bit 7 and zeros elsewhere. The acknowledge comes one clock after the qualifying edge.
- R10: Reset sets the control bit to 0 (late qualification), holds `int_req` low and `host_ack_n` high, and releases the data lane (`host_doe` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_as_n | input | 1 | Address strobe, active low |
| host_cs_n | input | 1 | Chip select, active low |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 15 | Access address |
| host_din | input | 8 | Write data from the bus |
| host_dout | output | 8 | Read data toward the bus |
| host_doe | output | 1 | Drive enable for the data bus pads |
| host_ack_n | output | 1 | Transfer acknowledge, active low, one clock |
| int_req | output | 1 | Internal access request |
| int_rnw | output | 1 | Latched read/write toward the internal port |
| int_addr | output | 15 | Latched address toward the internal port |
| int_wdata | output | 8 | Latched write data toward the internal port |
| int_rdata | input | 8 | Read data from the internal port, valid with done |
| int_done | input | 1 | Internal access complete, sampled while requesting |

## Verification
Accesses are run in both qualification modes. Chip select is placed on only the first edge, only the second edge, or both, so that a port sampling in the wrong cycle shows up as a dropped or phantom access. Latencies are drawn at random from 1 to 8, and the acknowledge edge is compared between modes to tell the early saving from an off-by-one. Address and data are scrambled right after the qualifying edge to expose late latching. Strobes are held low through and past the acknowledge to tell a proper return to idle from a re-triggered access.

// File: rtl/shp_pkg.sv
package shp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_QUAL  = 3'd1,
        ST_BUSY  = 3'd2,
        ST_LOCAL = 3'd3,
        ST_ACK   = 3'd4,
        ST_HOLD  = 3'd5
    } shp_state_e;

endpackage

// File: rtl/shp_cfg_reg.sv
// Holds the chip-select timing selector: 0 = qualify on the edge after the
// strobe, 1 = qualify on the strobe edge.
module shp_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic early_cs
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            early_cs <= 1'b0;
        end else if (wr_en) begin
            early_cs <= wr_bit;
        end
    end

    // R9: the selector only moves on a local write
    assert_cfg_write_only_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(early_cs)
    );

endmodule

// File: rtl/shp_fsm.sv
module shp_fsm
    import shp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic cs_n,
    input  logic early_cs,
    input  logic is_local,
    input  logic done,
    output logic capture,
    output logic req,
    output logic ack_n,
    output logic in_ack,
    output logic in_local
);

    shp_state_e state;
    shp_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and capture strobe
    always_comb begin
        nxt     = state;
        capture = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!as_n) begin
                    if (early_cs) begin
                        if (!cs_n) begin
                            capture = 1'b1;
                            nxt     = is_local ? ST_LOCAL : ST_BUSY;
                        end else begin
                            nxt = ST_HOLD;
                        end
                    end else begin
                        nxt = ST_QUAL;
                    end
                end
            end
            ST_QUAL: begin
                if (!cs_n) begin
                    capture = 1'b1;
                    nxt     = is_local ? ST_LOCAL : ST_BUSY;
                end else begin
                    nxt = ST_HOLD;
                end
            end
            ST_BUSY: begin
                if (done) begin
                    nxt = ST_ACK;
                end
            end
            ST_LOCAL: nxt = ST_ACK;
            ST_ACK:   nxt = as_n ? ST_IDLE : ST_HOLD;
            ST_HOLD: begin
                if (as_n) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        req      = (state == ST_BUSY);
        in_ack   = (state == ST_ACK);
        in_local = (state == ST_LOCAL);
        ack_n    = !in_ack;
    end

    assert_ack_single_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        !ack_n |=> ack_n
    );

    assert_done_to_ack_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req && done) |=> !ack_n
    );

    assert_req_hold_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req && !done) |=> req
    );

    assert_early_drop_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !as_n && early_cs && cs_n) |=> (!req && ack_n && !in_local)
    );

    assert_late_drop_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_QUAL && cs_n) |=> (!req && ack_n && !in_local)
    );

    assert_held_strobe_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !as_n) |=> (!req && ack_n && !in_local)
    );

endmodule

// File: rtl/shp_datapath.sv
module shp_datapath #(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int CFG_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              host_rnw,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_din,
    input  logic              busy,
    input  logic              done,
    input  logic              in_local,
    input  logic              in_ack,
    input  logic              early_cs,
    input  logic [DATA_W-1:0] int_rdata,
    output logic              lat_rnw,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              cfg_wr,
    output logic              cfg_bit,
    output logic [DATA_W-1:0] dout,
    output logic              doe
);

    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] local_rd;

    always_comb begin
        local_rd          = '0;
        local_rd[CFG_BIT] = early_cs;
    end

    // request fields, frozen from the qualifying edge onward
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_rnw   <= 1'b1;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (capture) begin
            lat_rnw   <= host_rnw;
            lat_addr  <= host_addr;
            lat_wdata <= host_din;
        end
    end

    // read return register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (busy && done) begin
            rdata_q <= int_rdata;
        end else if (in_local && lat_rnw) begin
            rdata_q <= local_rd;
        end
    end

    always_comb begin
        cfg_wr  = in_local && !lat_rnw;
        cfg_bit = lat_wdata[CFG_BIT];
        doe     = in_ack && lat_rnw;
        dout    = doe ? rdata_q : '0;
    end

    assert_fields_stable_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable({lat_rnw, lat_addr, lat_wdata})
    );

    assert_release_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        doe |=> !doe
    );

    assert_no_drive_on_write_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (busy && !lat_rnw) |=> !doe
    );

endmodule

// File: rtl/sync_host_port.sv
module sync_host_port #(
    parameter int                ADDR_W    = 15,
    parameter int                DATA_W    = 8,
    parameter int                CFG_BIT   = 7,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 15'h7F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_as_n,
    input  logic              host_cs_n,
    input  logic              host_rnw,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    output logic              host_ack_n,
    output logic              int_req,
    output logic              int_rnw,
    output logic [ADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata,
    input  logic [DATA_W-1:0] int_rdata,
    input  logic              int_done
);

    logic early_cs;
    logic is_local;
    logic capture;
    logic in_ack;
    logic in_local;
    logic cfg_wr;
    logic cfg_bit;

    assign is_local = (host_addr == CTRL_ADDR);

    shp_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_bit   (cfg_bit),
        .early_cs (early_cs)
    );

    shp_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_n     (host_as_n),
        .cs_n     (host_cs_n),
        .early_cs (early_cs),
        .is_local (is_local),
        .done     (int_done),
        .capture  (capture),
        .req      (int_req),
        .ack_n    (host_ack_n),
        .in_ack   (in_ack),
        .in_local (in_local)
    );

    shp_datapath #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CFG_BIT (CFG_BIT)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .host_rnw  (host_rnw),
        .host_addr (host_addr),
        .host_din  (host_din),
        .busy      (int_req),
        .done      (int_done),
        .in_local  (in_local),
        .in_ack    (in_ack),
        .early_cs  (early_cs),
        .int_rdata (int_rdata),
        .lat_rnw   (int_rnw),
        .lat_addr  (int_addr),
        .lat_wdata (int_wdata),
        .cfg_wr    (cfg_wr),
        .cfg_bit   (cfg_bit),
        .dout      (host_dout),
        .doe       (host_doe)
    );

    // R9: the local setting never reaches the internal port
    assert_local_no_req_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        in_local |-> !int_req
    );

endmodule

// File: tb/sync_host_port_bench.sv
module sync_host_port_bench;

    localparam logic [14:0] CTRL = 15'h7F00;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        as_n, cs_n, rnw;
    logic [14:0] addr;
    logic [7:0]  din;
    logic [7:0]  irdata;
    logic        idone;
    wire  [7:0]  dout;
    wire         doe, ack_n, req, irnw;
    wire  [14:0] iaddr;
    wire  [7:0]  iwd;

    int checks = 0;
    int fails  = 0;
    bit model_early = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sync_host_port u_sync_host_port (
        .clk(clk), .rst_n(rst_n),
        .host_as_n(as_n), .host_cs_n(cs_n), .host_rnw(rnw),
        .host_addr(addr), .host_din(din),
        .host_dout(dout), .host_doe(doe), .host_ack_n(ack_n),
        .int_req(req), .int_rnw(irnw), .int_addr(iaddr), .int_wdata(iwd),
        .int_rdata(irdata), .int_done(idone)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One bus access, checked against the behavioural model on every clock.
    task automatic access(input logic r, input logic [14:0] a, input logic [7:0] wd,
                          input logic [7:0] rdv, input bit cs0, input bit cs1,
                          input int lat, input bit hold, input string tag_over);
        bit    early    = model_early;
        bit    acc      = early ? cs0 : cs1;
        bit    loc      = (a == CTRL);
        int    acc_edge = early ? 0 : 1;
        int    n_ack    = acc_edge + (loc ? 1 : lat);
        int    last     = acc ? n_ack + 2 : 3;
        int    seen     = -1;
        string base;
        logic [7:0] exp_rd;
        exp_rd = loc ? {model_early, 7'b0} : rdv;
        if (tag_over != "") base = tag_over;
        else if (!acc) base = early ? "R2" : "R3";
        else if (loc) base = "R9";
        else base = "R6";
        for (int n = 0; n <= last; n++) begin
            bit xreq, xack, xdoe;
            string t;
            @(negedge clk);
            as_n = (n == 0) ? 1'b0 : ((hold && n < last) ? 1'b0 : 1'b1);
            cs_n = (n == 0) ? !cs0 : ((n == 1) ? !cs1 : !hold);
            if (n <= acc_edge) begin
                addr = a; rnw = r; din = wd;
            end else begin
                addr = a ^ 15'h5555; rnw = !r; din = ~wd;
            end
            idone  = acc && !loc && (n == acc_edge + lat);
            irdata = idone ? rdv : (8'hA5 ^ 8'(n));
            @(posedge clk);
            #1;
            xreq = acc && !loc && (n >= acc_edge) && (n < acc_edge + lat);
            xack = acc && (n == n_ack);
            xdoe = xack && r;
            t = (acc && n > n_ack) ? "R8" : base;
            chk((acc && n == acc_edge && tag_over == "") ? "R1" : t, "int_req", 32'(req), 32'(xreq));
            chk(t, "host_ack_n", 32'(ack_n), 32'(!xack));
            chk(acc ? "R7" : t, "host_doe", 32'(doe), 32'(xdoe));
            if (xdoe) chk(loc ? "R9" : "R7", "read data", 32'(dout), 32'(exp_rd));
            if (xreq) begin
                chk("R5", "int_addr", 32'(iaddr), 32'(a));
                chk("R5", "int_rnw", 32'(irnw), 32'(r));
                if (!r) chk("R5", "int_wdata", 32'(iwd), 32'(wd));
            end
            if (!ack_n) seen = n;
        end
        @(negedge clk);
        idone = 1'b0; as_n = 1'b1; cs_n = 1'b1;
        if (acc && !loc) chk("R4", "ack edge index", 32'(seen), 32'(early ? lat : lat + 1));
        if (acc && loc && !r) model_early = wd[7];
    endtask

    task automatic rand_access(input bit both_cs);
        logic [14:0] a = 15'($urandom);
        if (a == CTRL) a = a ^ 15'h0001;
        access(1'($urandom), a, 8'($urandom), 8'($urandom), both_cs | 1'($urandom),
               both_cs | 1'($urandom), int'($urandom_range(8, 1)), 1'($urandom), "");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; as_n = 1'b1; cs_n = 1'b1; rnw = 1'b1;
        addr = '0; din = '0; irdata = '0; idone = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "int_req in reset", 32'(req), 32'd0);
        chk("R10", "host_ack_n in reset", 32'(ack_n), 32'd1);
        chk("R10", "host_doe in reset", 32'(doe), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R10", "host_doe after reset", 32'(doe), 32'd0);
        // R10: selector at 0 means chip select only on the second edge qualifies
        access(1'b1, CTRL, 8'h00, 8'h00, 1'b0, 1'b1, 1, 1'b0, "R10");

        // late mode (R3)
        access(1'b1, 15'h0123, 8'h00, 8'h5A, 1'b1, 1'b1, 3, 1'b0, "");
        access(1'b0, 15'h2468, 8'hC3, 8'h00, 1'b0, 1'b1, 1, 1'b0, "");
        access(1'b1, 15'h0042, 8'h00, 8'h11, 1'b1, 1'b0, 2, 1'b0, "");
        access(1'b0, 15'h0042, 8'h77, 8'h00, 1'b1, 1'b0, 2, 1'b1, "");
        access(1'b1, 15'h1357, 8'h00, 8'hE1, 1'b1, 1'b1, 4, 1'b1, "");
        for (int i = 0; i < 10; i++) rand_access(1'b0);

        // switch to early mode (R9)
        access(1'b0, CTRL, 8'h80, 8'h00, 1'b1, 1'b1, 1, 1'b0, "");
        access(1'b1, CTRL, 8'h00, 8'h00, 1'b1, 1'b0, 1, 1'b0, "");

        // early mode (R2, R4)
        access(1'b1, 15'h0123, 8'h00, 8'h5A, 1'b1, 1'b1, 3, 1'b0, "");
        access(1'b1, 15'h0099, 8'h00, 8'h22, 1'b0, 1'b1, 3, 1'b0, "");
        access(1'b0, 15'h0099, 8'h33, 8'h00, 1'b0, 1'b1, 3, 1'b1, "");
        access(1'b0, 15'h3FFF, 8'h9C, 8'h00, 1'b1, 1'b0, 5, 1'b1, "");
        for (int i = 0; i < 10; i++) rand_access(1'b0);

        // back to late mode: bit 7 clear, other bits set
        access(1'b0, CTRL, 8'h7F, 8'h00, 1'b1, 1'b0, 1, 1'b0, "");
        access(1'b1, CTRL, 8'h00, 8'h00, 1'b0, 1'b1, 1, 1'b0, "");
        for (int i = 0; i < 10; i++) rand_access(1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule